// File: doc/BRIEF.md
# LCD Interrupt Status Aggregator

This block gathers the interrupt events of a seven-channel display DMA engine and of the panel control logic into two status registers, and drives a single level-sensitive interrupt line. DMA events arrive as one-cycle strobes (start of frame, end of frame, branch taken, bus error, input underrun) tagged with a channel number, that channel's current frame ID and the two interrupt-enable bits of its current descriptor command. Panel events (last frame done, AC-bias count, output underrun, read status, command done) arrive on their own strobes.

Software sees five registers through a simple write/combinational-read port: the main control register (enable bit plus mask bits for the channel-0 and panel sources), the per-channel mask register, the two status registers (write one to clear), and the interrupt ID register. The first unmasked frame event seen while the interrupt line is low records the frame ID of its channel; a frame event that arrives while the line is already high only sets a "subsequent interrupt" flag, so the ID of the first cause is kept.

Top module: `lcd_irq_agg`

## Requirements
- R1: Status register 0 (address 2) records events at fixed bits: 0 last frame done, 1 channel-0 start of frame, 2 bus error, 3 AC-bias count, 4 channel-0 underrun, 5 channel-1 underrun, 6 output underrun, 7 quick-disable done, 8 channel-0 end of frame, 9 channel-0 branch, 10 subsequent interrupt, 11 read status, 12 command done, bits 30:28 the bus-error channel.
- R2: For channel c in 1..6, status register 1 (address 3) holds start of frame at bit c-1, end of frame at bit c+7 and branch at bit c+15; the mask register (address 1) masks each with the bit at the same position.
- R3: irq_o is a register, updated every cycle to the OR of the status-0 sources (bits 0,1,4,5,6,7,8,9,11,12) whose masks are clear (control bits 3,4,5 for bits 0,1,4; mask-register bit 23 for bit 5; control bits 21,11,6,20,23,24 for bits 6,7,8,9,11,12) and of every status-1 bit whose mask-register bit is clear; it follows status and masks one cycle later. Bus error, AC-bias and subsequent-interrupt bits never drive it.
- R4: A start-of-frame strobe is recorded only when evt_sof_en_i is 1, an end-of-frame strobe only when evt_eof_en_i is 1.
- R5: A recorded, unmasked start-of-frame, end-of-frame or branch event, or any bus error, arriving while irq_o is 0 copies evt_fid_i into the ID register (address 4).
- R6: Such an event arriving while irq_o is 1 sets status-0 bit 10 and leaves the ID register unchanged.
- R7: A bus error sets status-0 bit 2 and writes the channel into bits 30:28 regardless of every mask.
- R8: Writing status register 0 clears each set bit among bits 11:0 where the write data holds a 1; bit 12 is not clearable; writing 1 to bit 2 also zeroes bits 30:28. Writing status register 1 clears only bits under 0x003E3F3F.
- R9: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R10: Writing the control register (address 0) with bit 0 = 0 while its stored bit 0 is 1 sets status-0 bit 7.
- R11: The control register keeps bits 26:0 of a write; the mask register keeps bits under 0x3F3F3F3F (so bit 23 always reads 0 and channel-1 underrun cannot be masked).
- R12: DMA strobes carrying channel 7 change no register.
- R13: After reset every register reads 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_ch_i | input | 3 | Channel tag of the DMA strobes |
| evt_fid_i | input | ID_W | Frame ID of the tagged channel |
| evt_sof_en_i | input | 1 | Descriptor enables start-of-frame interrupt |
| evt_eof_en_i | input | 1 | Descriptor enables end-of-frame interrupt |
| evt_sof_i | input | 1 | Start-of-frame strobe |
| evt_eof_i | input | 1 | End-of-frame strobe |
| evt_bs_i | input | 1 | Branch-taken strobe |
| evt_ber_i | input | 1 | Bus-error strobe |
| evt_iu_i | input | 1 | Input-underrun strobe (channels 0 and 1) |
| pnl_ldd_i | input | 1 | Last frame done after disable |
| pnl_abc_i | input | 1 | AC-bias count reached |
| pnl_ou_i | input | 1 | Output underrun |
| pnl_rdst_i | input | 1 | Panel read status ready |
| pnl_cmd_i | input | 1 | Panel command done |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (0..4) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bench chases the ID-versus-subsequent-flag decision at the moment irq_o is already high, where a design that consulted the next-cycle level would overwrite the first cause's ID. It hits the same status bit with an event and a clearing write in one cycle, and a design that let the clear win would lose the branch event. It covers the unclearable command bit, the bus-error channel field vanishing with its flag, the channel-1 underrun that no mask can silence, masked events that must still record status without touching the ID, and channel-7 strobes that a loose range check would let through. A reference model predicts irq_o every cycle, so an interrupt line that is combinational or late by a cycle shows up at once.

// File: rtl/lcd_irq_pkg.sv
package lcd_irq_pkg;
  localparam int DW     = 32;
  localparam int BCH_W  = 3;
  localparam int SRC0_W = 13;

  // status 0 bit positions
  localparam int S0_LDD  = 0;
  localparam int S0_SOF  = 1;
  localparam int S0_BER  = 2;
  localparam int S0_ABC  = 3;
  localparam int S0_IU0  = 4;
  localparam int S0_IU1  = 5;
  localparam int S0_OU   = 6;
  localparam int S0_QD   = 7;
  localparam int S0_EOF  = 8;
  localparam int S0_BS   = 9;
  localparam int S0_SINT = 10;
  localparam int S0_RDST = 11;
  localparam int S0_CMD  = 12;
  localparam int S0_BCH  = 28;

  // control 0 mask positions
  localparam int C0_EN    = 0;
  localparam int C0_MLDD  = 3;
  localparam int C0_MSOF  = 4;
  localparam int C0_MIU   = 5;
  localparam int C0_MEOF  = 6;
  localparam int C0_MQD   = 11;
  localparam int C0_MBS   = 20;
  localparam int C0_MOU   = 21;
  localparam int C0_MRDST = 23;
  localparam int C0_MCMD  = 24;
  localparam int C5_MIU1  = 23;

  // per-channel field bases in status 1 / mask register
  localparam int S1_EOF_B = 8;
  localparam int S1_BS_B  = 16;

  localparam logic [DW-1:0] C0_KEEP = 32'h07ff_ffff;
  localparam logic [DW-1:0] C5_KEEP = 32'h3f3f_3f3f;
  localparam logic [DW-1:0] S0_W1C  = 32'h0000_0fff;
  localparam logic [DW-1:0] S1_W1C  = 32'h003e_3f3f;

  localparam logic [2:0] A_CTRL0 = 3'd0;
  localparam logic [2:0] A_CTRL5 = 3'd1;
  localparam logic [2:0] A_STAT0 = 3'd2;
  localparam logic [2:0] A_STAT1 = 3'd3;
  localparam logic [2:0] A_IDR   = 3'd4;
endpackage

// File: rtl/lcd_irq_ctrl_regs.sv
module lcd_irq_ctrl_regs
  import lcd_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_c0_i,
  input  logic          wr_c5_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl0_o,
  output logic [DW-1:0] ctrl5_o,
  output logic          qd_set_o
);
  logic [DW-1:0] ctrl0_q, ctrl5_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl0_q <= '0;
      ctrl5_q <= '0;
    end else begin
      if (wr_c0_i) ctrl0_q <= wdata_i & C0_KEEP;
      if (wr_c5_i) ctrl5_q <= wdata_i & C5_KEEP;
    end
  end

  // enable falling by software write -> quick disable done
  assign qd_set_o = wr_c0_i && ctrl0_q[C0_EN] && !wdata_i[C0_EN];
  assign ctrl0_o  = ctrl0_q;
  assign ctrl5_o  = ctrl5_q;
endmodule

// File: rtl/lcd_irq_evt_decode.sv
module lcd_irq_evt_decode
  import lcd_irq_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic [BCH_W-1:0]  ch_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              bs_i,
  input  logic              ber_i,
  input  logic              iu_i,
  input  logic              sof_en_i,
  input  logic              eof_en_i,
  input  logic [NUM_CH-1:0] sof_msk_i,
  input  logic [NUM_CH-1:0] eof_msk_i,
  input  logic [NUM_CH-1:0] bs_msk_i,
  output logic [DW-1:0]     set0_o,
  output logic [DW-1:0]     set1_o,
  output logic              ber_o,
  output logic              touch_o
);
  logic              ch_ok, sof_rec, eof_rec, bs_rec;
  logic [NUM_CH-1:0] hit, unm;

  assign ch_ok   = {1'b0, ch_i} < (BCH_W+1)'(NUM_CH);
  assign sof_rec = sof_i && sof_en_i && ch_ok;
  assign eof_rec = eof_i && eof_en_i && ch_ok;
  assign bs_rec  = bs_i && ch_ok;
  assign ber_o   = ber_i && ch_ok;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign hit[g] = ch_ok && (ch_i == BCH_W'(g));
    assign unm[g] = hit[g] && ((sof_rec && !sof_msk_i[g]) ||
                               (eof_rec && !eof_msk_i[g]) ||
                               (bs_rec  && !bs_msk_i[g]));
  end

  always_comb begin
    set0_o         = '0;
    set0_o[S0_SOF] = sof_rec && hit[0];
    set0_o[S0_EOF] = eof_rec && hit[0];
    set0_o[S0_BS]  = bs_rec && hit[0];
    set0_o[S0_BER] = ber_o;
    set0_o[S0_IU0] = iu_i && hit[0];
    set0_o[S0_IU1] = iu_i && hit[1];
    set1_o = '0;
    for (int k = 1; k < NUM_CH; k++) begin
      set1_o[k-1]        = sof_rec && hit[k];
      set1_o[k+S1_EOF_B-1] = eof_rec && hit[k];
      set1_o[k+S1_BS_B-1]  = bs_rec && hit[k];
    end
  end

  assign touch_o = (|unm) || ber_o;
endmodule

// File: rtl/lcd_irq_status.sv
module lcd_irq_status
  import lcd_irq_pkg::*;
#(
  parameter int ID_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DW-1:0]     set0_i,
  input  logic [DW-1:0]     set1_i,
  input  logic [DW-1:0]     clr0_i,
  input  logic [DW-1:0]     clr1_i,
  input  logic              ber_i,
  input  logic [BCH_W-1:0]  ber_ch_i,
  input  logic              touch_i,
  input  logic [ID_W-1:0]   fid_i,
  input  logic [SRC0_W-1:0] msk0_i,
  input  logic [DW-1:0]     ctrl5_i,
  output logic [DW-1:0]     stat0_o,
  output logic [DW-1:0]     stat1_o,
  output logic [ID_W-1:0]   id_o,
  output logic              irq_o
);
  logic [DW-1:0]   stat0_q, stat1_q, stat0_n, stat1_n;
  logic [ID_W-1:0] id_q;
  logic            irq_q, irq_n;

  always_comb begin
    stat0_n = (stat0_q & ~clr0_i) | set0_i;
    if (touch_i && irq_q) stat0_n[S0_SINT] = 1'b1;
    if (ber_i) stat0_n[S0_BCH +: BCH_W] = ber_ch_i;
    stat1_n = (stat1_q & ~clr1_i) | set1_i;
    irq_n   = (|(stat0_q[SRC0_W-1:0] & ~msk0_i)) || (|(stat1_q & ~ctrl5_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat0_q <= '0;
      stat1_q <= '0;
      id_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      stat0_q <= stat0_n;
      stat1_q <= stat1_n;
      irq_q   <= irq_n;
      if (touch_i && !irq_q) id_q <= fid_i;
    end
  end

  assign stat0_o = stat0_q;
  assign stat1_o = stat1_q;
  assign id_o    = id_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/lcd_irq_agg.sv
module lcd_irq_agg
  import lcd_irq_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int ID_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BCH_W-1:0] evt_ch_i,
  input  logic [ID_W-1:0]  evt_fid_i,
  input  logic             evt_sof_en_i,
  input  logic             evt_eof_en_i,
  input  logic             evt_sof_i,
  input  logic             evt_eof_i,
  input  logic             evt_bs_i,
  input  logic             evt_ber_i,
  input  logic             evt_iu_i,
  input  logic             pnl_ldd_i,
  input  logic             pnl_abc_i,
  input  logic             pnl_ou_i,
  input  logic             pnl_rdst_i,
  input  logic             pnl_cmd_i,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_o
);
  logic [DW-1:0]     ctrl0, ctrl5, stat0, stat1;
  logic [DW-1:0]     dec_set0, dec_set1, set0, clr0, clr1;
  logic [ID_W-1:0]   id_q;
  logic [NUM_CH-1:0] sof_msk, eof_msk, bs_msk;
  logic [SRC0_W-1:0] msk0;
  logic              qd_set, ber_hit, touch;
  logic              wr_c0, wr_c5, wr_s0, wr_s1;

  assign wr_c0 = reg_we_i && (reg_addr_i == A_CTRL0);
  assign wr_c5 = reg_we_i && (reg_addr_i == A_CTRL5);
  assign wr_s0 = reg_we_i && (reg_addr_i == A_STAT0);
  assign wr_s1 = reg_we_i && (reg_addr_i == A_STAT1);

  lcd_irq_ctrl_regs u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_c0_i  (wr_c0),
    .wr_c5_i  (wr_c5),
    .wdata_i  (reg_wdata_i),
    .ctrl0_o  (ctrl0),
    .ctrl5_o  (ctrl5),
    .qd_set_o (qd_set)
  );

  // channel 0 masks live in control 0, the rest in control 5
  for (genvar g = 0; g < NUM_CH; g++) begin : g_msk
    if (g == 0) begin : g_c0
      assign sof_msk[g] = ctrl0[C0_MSOF];
      assign eof_msk[g] = ctrl0[C0_MEOF];
      assign bs_msk[g]  = ctrl0[C0_MBS];
    end else begin : g_c5
      assign sof_msk[g] = ctrl5[g-1];
      assign eof_msk[g] = ctrl5[g+S1_EOF_B-1];
      assign bs_msk[g]  = ctrl5[g+S1_BS_B-1];
    end
  end

  lcd_irq_evt_decode #(.NUM_CH(NUM_CH)) u_dec (
    .ch_i      (evt_ch_i),
    .sof_i     (evt_sof_i),
    .eof_i     (evt_eof_i),
    .bs_i      (evt_bs_i),
    .ber_i     (evt_ber_i),
    .iu_i      (evt_iu_i),
    .sof_en_i  (evt_sof_en_i),
    .eof_en_i  (evt_eof_en_i),
    .sof_msk_i (sof_msk),
    .eof_msk_i (eof_msk),
    .bs_msk_i  (bs_msk),
    .set0_o    (dec_set0),
    .set1_o    (dec_set1),
    .ber_o     (ber_hit),
    .touch_o   (touch)
  );

  always_comb begin
    set0          = dec_set0;
    set0[S0_LDD]  = pnl_ldd_i;
    set0[S0_ABC]  = pnl_abc_i;
    set0[S0_OU]   = pnl_ou_i;
    set0[S0_QD]   = qd_set;
    set0[S0_RDST] = pnl_rdst_i;
    set0[S0_CMD]  = pnl_cmd_i;

    clr0 = wr_s0 ? (reg_wdata_i & S0_W1C) : '0;
    if (wr_s0 && reg_wdata_i[S0_BER]) clr0[S0_BCH +: BCH_W] = '1;
    clr1 = wr_s1 ? (reg_wdata_i & S1_W1C) : '0;

    // 1 = not an interrupt source
    msk0          = '1;
    msk0[S0_LDD]  = ctrl0[C0_MLDD];
    msk0[S0_SOF]  = ctrl0[C0_MSOF];
    msk0[S0_IU0]  = ctrl0[C0_MIU];
    msk0[S0_IU1]  = ctrl5[C5_MIU1];
    msk0[S0_OU]   = ctrl0[C0_MOU];
    msk0[S0_QD]   = ctrl0[C0_MQD];
    msk0[S0_EOF]  = ctrl0[C0_MEOF];
    msk0[S0_BS]   = ctrl0[C0_MBS];
    msk0[S0_RDST] = ctrl0[C0_MRDST];
    msk0[S0_CMD]  = ctrl0[C0_MCMD];
  end

  lcd_irq_status #(.ID_W(ID_W)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set0_i   (set0),
    .set1_i   (dec_set1),
    .clr0_i   (clr0),
    .clr1_i   (clr1),
    .ber_i    (ber_hit),
    .ber_ch_i (evt_ch_i),
    .touch_i  (touch),
    .fid_i    (evt_fid_i),
    .msk0_i   (msk0),
    .ctrl5_i  (ctrl5),
    .stat0_o  (stat0),
    .stat1_o  (stat1),
    .id_o     (id_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    case (reg_addr_i)
      A_CTRL0: reg_rdata_o = ctrl0;
      A_CTRL5: reg_rdata_o = ctrl5;
      A_STAT0: reg_rdata_o = stat0;
      A_STAT1: reg_rdata_o = stat1;
      A_IDR:   reg_rdata_o = DW'(id_q);
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lcd_irq_agg_chk.sv
module lcd_irq_agg_chk
  import lcd_irq_pkg::*;
#(
  parameter int ID_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             reg_we_i,
  input logic [2:0]       reg_addr_i,
  input logic [DW-1:0]    reg_wdata_i,
  input logic [BCH_W-1:0] evt_ch_i,
  input logic [ID_W-1:0]  evt_fid_i,
  input logic             evt_ber_i,
  input logic             evt_any_i,
  input logic             pnl_any_i,
  input logic             pnl_ldd_i,
  input logic [DW-1:0]    ctrl0,
  input logic [DW-1:0]    ctrl5,
  input logic [DW-1:0]    stat0,
  input logic [DW-1:0]    stat1,
  input logic [ID_W-1:0]  id_q
);
  localparam logic [DW-1:0] ALL_M0 = 32'h01b0_0878;

  // R7
  a_r7_ber_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_ber_i && evt_ch_i != 3'd7) |=> (stat0[S0_BER] && stat0[S0_BCH +: BCH_W] == $past(evt_ch_i)));

  // R6
  a_r6_sint_when_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_ber_i && evt_ch_i != 3'd7 && irq_o) |=> (stat0[S0_SINT] && $stable(id_q)));

  // R5
  a_r5_id_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_ber_i && evt_ch_i != 3'd7 && !irq_o) |=> (id_q == $past(evt_fid_i)));

  // R10
  a_r10_qd_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_CTRL0 && ctrl0[C0_EN] && !reg_wdata_i[C0_EN]) |=> stat0[S0_QD]);

  // R3: everything masked except the unmaskable channel-1 underrun
  a_r3_all_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((ctrl0 & ALL_M0) == ALL_M0) && ctrl5 == C5_KEEP && !stat0[S0_IU1]) |=> !irq_o);

  // R8
  a_r8_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_STAT0 && reg_wdata_i[S0_LDD] && !pnl_ldd_i) |=> !stat0[S0_LDD]);

  // R12
  a_r12_bad_ch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_ch_i == 3'd7 && !pnl_any_i && !reg_we_i) |=> ($stable(stat0) && $stable(stat1) && $stable(id_q)));

  // R11
  a_r11_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_any_i |-> ((ctrl0 & ~C0_KEEP) == '0 && (ctrl5 & ~C5_KEEP) == '0));
endmodule

bind lcd_irq_agg lcd_irq_agg_chk #(.ID_W(ID_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_o       (irq_o),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .evt_ch_i    (evt_ch_i),
  .evt_fid_i   (evt_fid_i),
  .evt_ber_i   (evt_ber_i),
  .evt_any_i   (evt_sof_i || evt_eof_i || evt_bs_i || evt_ber_i || evt_iu_i),
  .pnl_any_i   (pnl_ldd_i || pnl_abc_i || pnl_ou_i || pnl_rdst_i || pnl_cmd_i),
  .pnl_ldd_i   (pnl_ldd_i),
  .ctrl0       (ctrl0),
  .ctrl5       (ctrl5),
  .stat0       (stat0),
  .stat1       (stat1),
  .id_q        (id_q)
);

// File: tb/tb_lcd_irq_agg.sv
module tb_lcd_irq_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ch = '0;
  logic [31:0] fid = '0;
  logic        sof_en = 0, eof_en = 0, sof = 0, eof = 0, bs = 0, ber = 0, iu = 0;
  logic        ldd = 0, abc = 0, ou = 0, rdst = 0, cmd = 0;
  logic        we = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit running = 0;

  always #10 clk = ~clk;

  lcd_irq_agg dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_ch_i(ch), .evt_fid_i(fid),
    .evt_sof_en_i(sof_en), .evt_eof_en_i(eof_en), .evt_sof_i(sof), .evt_eof_i(eof),
    .evt_bs_i(bs), .evt_ber_i(ber), .evt_iu_i(iu),
    .pnl_ldd_i(ldd), .pnl_abc_i(abc), .pnl_ou_i(ou), .pnl_rdst_i(rdst), .pnl_cmd_i(cmd),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model of the register state
  logic [31:0] m_s0, m_s1, m_id, m_c0, m_c5;
  logic        m_irq;

  always @(posedge clk or negedge rst_n) begin : model
    logic [31:0] st0, st1;
    logic        lvl, tch, ok;
    if (!rst_n) begin
      m_s0 = 0; m_s1 = 0; m_id = 0; m_c0 = 0; m_c5 = 0; m_irq = 0;
    end else begin
      lvl = (m_s0[0] && !m_c0[3]) || (m_s0[1] && !m_c0[4]) || (m_s0[4] && !m_c0[5]) ||
            (m_s0[5] && !m_c5[23]) || (m_s0[6] && !m_c0[21]) || (m_s0[7] && !m_c0[11]) ||
            (m_s0[8] && !m_c0[6]) || (m_s0[9] && !m_c0[20]) || (m_s0[11] && !m_c0[23]) ||
            (m_s0[12] && !m_c0[24]) || ((m_s1 & ~m_c5) != 0);
      st0 = m_s0; st1 = m_s1; tch = 0; ok = (ch < 7);
      if (we && addr == 2) begin
        st0 = st0 & ~(wdata & 32'hfff);
        if (wdata[2]) st0[30:28] = 0;
      end
      if (we && addr == 3) st1 = st1 & ~(wdata & 32'h003e3f3f);
      if (ok && sof && sof_en) begin
        if (ch == 0) begin st0[1] = 1; if (!m_c0[4]) tch = 1; end
        else begin st1[ch-1] = 1; if (!m_c5[ch-1]) tch = 1; end
      end
      if (ok && eof && eof_en) begin
        if (ch == 0) begin st0[8] = 1; if (!m_c0[6]) tch = 1; end
        else begin st1[ch+7] = 1; if (!m_c5[ch+7]) tch = 1; end
      end
      if (ok && bs) begin
        if (ch == 0) begin st0[9] = 1; if (!m_c0[20]) tch = 1; end
        else begin st1[ch+15] = 1; if (!m_c5[ch+15]) tch = 1; end
      end
      if (ok && ber) begin st0[2] = 1; st0[30:28] = ch; tch = 1; end
      if (iu && ch == 0) st0[4] = 1;
      if (iu && ch == 1) st0[5] = 1;
      if (ldd)  st0[0] = 1;
      if (abc)  st0[3] = 1;
      if (ou)   st0[6] = 1;
      if (rdst) st0[11] = 1;
      if (cmd)  st0[12] = 1;
      if (we && addr == 0 && m_c0[0] && !wdata[0]) st0[7] = 1;
      if (tch && m_irq) st0[10] = 1;
      if (tch && !m_irq) m_id = fid;
      if (we && addr == 0) m_c0 = wdata & 32'h07ffffff;
      if (we && addr == 1) m_c5 = wdata & 32'h3f3f3f3f;
      m_s0 = st0; m_s1 = st1; m_irq = lvl;
    end
  end

  // irq_o against the model every clock (R3)
  always @(negedge clk) begin
    if (running) begin
      checks++;
      if (irq !== m_irq) begin
        fails++;
        $display("FAIL R3 irq_o per-cycle: actual %0b expected %0b at %0t", irq, m_irq, $time);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    we = 0; addr = a;
    #2;
    chk(rdata, exp, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0; wdata = 0;
  endtask

  task automatic ev(input logic s, input logic e, input logic b, input logic r, input logic u,
                    input logic [2:0] c, input logic [31:0] f, input logic se, input logic ee);
    @(negedge clk);
    sof = s; eof = e; bs = b; ber = r; iu = u; ch = c; fid = f; sof_en = se; eof_en = ee;
    @(negedge clk);
    sof = 0; eof = 0; bs = 0; ber = 0; iu = 0; ch = 0; sof_en = 0; eof_en = 0;
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1;
    running = 1;
    // R13 reset state
    rd(3'd0, 32'h0, "R13 ctrl0 reset");
    rd(3'd2, 32'h0, "R13 stat0 reset");
    rd(3'd4, 32'h0, "R13 id reset");
    chk({31'd0, irq}, 32'd0, "R13 irq reset");

    // R11 write masks
    wr(3'd1, 32'hffff_ffff);
    rd(3'd1, 32'h3f3f_3f3f, "R11 ctrl5 keep mask");
    wr(3'd0, 32'hffff_ffff);
    rd(3'd0, 32'h07ff_ffff, "R11 ctrl0 keep mask");
    rd(3'd2, 32'h0, "R10 enabling does not set quick-disable");

    // R10 disable -> quick-disable done, unmasked now
    wr(3'd0, 32'h0);
    rd(3'd2, 32'h0000_0080, "R10 quick-disable bit7");
    chk({31'd0, irq}, 32'd1, "R3 quick-disable unmasked raises irq");

    // R8 clear
    wr(3'd2, 32'h0000_0fff);
    rd(3'd2, 32'h0, "R8 stat0 w1c");
    wr(3'd1, 32'h0);
    @(negedge clk);
    chk({31'd0, irq}, 32'd0, "R3 irq low after clear");

    // R5 first event loads ID
    ev(1, 0, 0, 0, 0, 3'd0, 32'h11, 1, 0);
    rd(3'd2, 32'h0000_0002, "R1 channel-0 start of frame bit1");
    rd(3'd4, 32'h0000_0011, "R5 id loaded");
    chk({31'd0, irq}, 32'd1, "R3 sof0 raises irq");

    // R6 second event with irq high
    ev(0, 1, 0, 0, 0, 3'd3, 32'h22, 0, 1);
    rd(3'd3, 32'h0000_0400, "R2 ch3 end of frame bit10");
    rd(3'd2, 32'h0000_0402, "R6 subsequent flag set");
    rd(3'd4, 32'h0000_0011, "R6 id kept");

    // R4 enables gate recording
    ev(1, 0, 0, 0, 0, 3'd2, 32'h33, 0, 1);
    ev(0, 1, 0, 0, 0, 3'd0, 32'h33, 1, 0);
    rd(3'd3, 32'h0000_0400, "R4 sof without enable ignored");
    rd(3'd2, 32'h0000_0402, "R4 eof without enable ignored");

    wr(3'd3, 32'hffff_ffff);
    rd(3'd3, 32'h0, "R8 stat1 clear");
    wr(3'd2, 32'h0000_0fff);
    rd(3'd2, 32'h0, "R8 stat0 clear incl subsequent flag");

    // masked operation
    wr(3'd1, 32'h3f3f_3f3f);
    wr(3'd0, 32'h01b0_0878);
    ev(0, 0, 1, 0, 0, 3'd5, 32'h55, 0, 0);
    rd(3'd3, 32'h0010_0000, "R2 ch5 branch bit20");
    rd(3'd4, 32'h0000_0011, "R5 masked event leaves id");
    chk({31'd0, irq}, 32'd0, "R3 masked branch keeps irq low");

    // R7 bus error ignores masks
    ev(0, 0, 0, 1, 0, 3'd4, 32'h44, 0, 0);
    rd(3'd2, 32'h4000_0004, "R7 bus error flag and channel");
    rd(3'd4, 32'h0000_0044, "R7 bus error loads id");
    chk({31'd0, irq}, 32'd0, "R3 bus error is not an irq source");
    wr(3'd2, 32'h0000_0004);
    rd(3'd2, 32'h0, "R8 clearing bus error zeroes channel");

    // R9 set wins
    @(negedge clk);
    bs = 1; ch = 3'd0; we = 1; addr = 3'd2; wdata = 32'h0000_0200;
    @(negedge clk);
    bs = 0; we = 0; wdata = 0;
    rd(3'd2, 32'h0000_0200, "R9 set beats clear");

    // R12 channel 7
    ev(1, 1, 1, 1, 1, 3'd7, 32'h77, 1, 1);
    rd(3'd2, 32'h0000_0200, "R12 ch7 stat0 unchanged");
    rd(3'd3, 32'h0010_0000, "R12 ch7 stat1 unchanged");
    rd(3'd4, 32'h0000_0044, "R12 ch7 id unchanged");

    // panel sources + channel-1 underrun
    @(negedge clk);
    ldd = 1; abc = 1; ou = 1; rdst = 1; cmd = 1; iu = 1; ch = 3'd1;
    @(negedge clk);
    ldd = 0; abc = 0; ou = 0; rdst = 0; cmd = 0; iu = 0; ch = 0;
    rd(3'd2, 32'h0000_1a69, "R1 panel and underrun bits");
    chk({31'd0, irq}, 32'd1, "R3 channel-1 underrun unmaskable");

    // R8 command bit not clearable
    wr(3'd2, 32'hffff_ffff);
    rd(3'd2, 32'h0000_1000, "R8 bit12 survives clear");
    chk({31'd0, irq}, 32'd0, "R3 masked command bit keeps irq low");
    wr(3'd0, 32'h0);
    @(negedge clk);
    chk({31'd0, irq}, 32'd1, "R3 unmasking command bit raises irq");

    repeat (3) @(negedge clk);
    running = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule